// File: doc/BRIEF.md
# Supply-Fail Memory Guard

This block sits between a host and a battery-backed static memory and decides, from the state of the main supply, whether the memory may be accessed at all. Three comparator flags arrive from analog circuits outside the block. One says the supply is above the upper protect threshold. One says it is above the lower protect threshold. The third says it is above the level at which memory power must move to the battery. Each flag is synchronised and then filtered before it is used, so short supply spikes do not change the block's state.

While the supply is healthy, the host's chip-enable, write-enable and output-enable pass straight to the memory. When the supply sags below the upper threshold, the memory is cut off from the host: no new access is accepted and the data outputs are held off. One exception applies. A write that is already under way may finish within a bounded grace period, so that at most the location being written can be damaged. If the host still has a write active at the moment of power-down, a one-cycle violation pulse is raised. Below the switchover level, the block selects battery power. When the supply comes back, access is re-enabled only after a recovery delay that runs from the time the supply is seen above the upper threshold. A dip during that delay restarts it.

The delays are set in real time units and converted to clock cycles from a clock-frequency parameter: the recovery delay in milliseconds (40 to 200 ms is the intended range) and the write grace in microseconds.

Top module: `pfail_guard`

## Requirements
- R1: After reset the block is in the protected (deselected) state: accessOk, memCe, memWe and outEnable are all 0 whatever the host drives.
- R2: In the normal state the gating is: memCe = hostCe, memWe = hostCe AND hostWe, outEnable = hostCe AND hostOe AND NOT hostWe, with accessOk = 1 (all signals active high).
- R3: accessOk rises no sooner than REC_CYC = CLK_HZ*REC_MS/1000 clock cycles after the upper-threshold flag rises, and no later than that plus the synchroniser and filter latency plus a few cycles.
- R4: If the upper-threshold flag falls during the recovery delay, the block returns to the protected state, and the full delay is counted again from the next rise.
- R5: Once the upper-threshold flag has been low past the filter, accessOk is 0, outEnable is 0, and host chip-enable and write-enable have no effect on memCe or memWe, apart from the write grace of R8.
- R6: When the switchover flag goes low, battSel goes to 1 and memCe, memWe and accessOk are 0. When it returns high, battSel goes to 0 and the block stays protected until a full recovery delay has run.
- R7: A flag change that lasts fewer than FILT_CYC clock cycles after synchronisation is ignored. For example, a 3-cycle low glitch on the upper-threshold flag with FILT_CYC = 4 leaves accessOk at 1.
- R8: If a host write (hostCe and hostWe both 1) is active when the block leaves the normal state for the protected state, memWe and memCe stay 1. They remain so until the host drops the write, GRACE_CYC = CLK_HZ*GRACE_US/1e6 cycles pass, or the lower-threshold or switchover flag falls, whichever comes first. A write dropped during the grace cannot be restarted.
- R9: violation pulses high for exactly one cycle when the block leaves the normal state while a host write is active, and stays low when no write is active at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of frequency CLK_HZ |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyAboveHi | input | 1 | Asynchronous flag: supply above upper protect threshold |
| supplyAboveLo | input | 1 | Asynchronous flag: supply above lower protect threshold |
| supplyAboveSw | input | 1 | Asynchronous flag: supply above battery switchover level |
| hostCe | input | 1 | Host chip-enable, active high |
| hostWe | input | 1 | Host write-enable, active high |
| hostOe | input | 1 | Host output-enable, active high |
| memCe | output | 1 | Gated chip-enable to the memory |
| memWe | output | 1 | Gated write-enable to the memory |
| outEnable | output | 1 | Data output drive enable; 0 means outputs high impedance |
| battSel | output | 1 | 1 selects battery power for the memory |
| accessOk | output | 1 | 1 in the normal state, when host access is allowed |
| violation | output | 1 | One-cycle pulse: write active at power-down |

## Verification
A wrong internal state shows first at accessOk and outEnable. A guard stuck in the normal state leaves both high seconds after the upper flag has fallen. One stuck in recovery never raises accessOk, and this is caught within one recovery window plus a small latency. A recovery counter that is not cleared by a dip raises accessOk early after the second rise, and the bench measures that interval to the cycle. A broken write grace shows at memWe within the grace window: the write is cut off too soon, is kept past a lower-threshold drop, or comes back after the host has let go. The filter is exercised with glitches one cycle shorter than its length, and the gated signals are compared with the expected table under random host traffic in both the normal and the protected state.

// File: rtl/pfail_guard_pkg.sv
package pfail_guard_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DESEL  = 2'd1,
    ST_BATT   = 2'd2,
    ST_RECOV  = 2'd3
  } guardStateT;

  typedef struct packed {
    logic allow;       // host access passes through
    logic battery;     // battery power selected
    logic recRun;      // recovery timer counts
    logic graceStart;  // open write grace window
    logic graceKill;   // hard stop of any grace
    logic violate;     // write was active at power-down
  } guardStrobeT;

endpackage

// File: rtl/pfail_flag_filter.sv
module pfail_flag_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic syncA, syncB;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      cleanOut <= 1'b0;
    end else if (syncB == cleanOut) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_CYC - 1)) begin
      runCnt   <= '0;
      cleanOut <= syncB;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfail_guard_ctrl.sv
module pfail_guard_ctrl
  import pfail_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hiOk,
  input  logic        loOk,
  input  logic        swOk,
  input  logic        hostWrite,
  input  logic        recDone,
  output guardStrobeT strb
);
  guardStateT curState, nextState;

  always_comb begin
    nextState = curState;
    if (!swOk) begin
      nextState = ST_BATT;
    end else begin
      unique case (curState)
        ST_NORMAL: if (!hiOk) nextState = ST_DESEL;
        ST_DESEL:  if (hiOk)  nextState = ST_RECOV;
        ST_BATT:              nextState = ST_DESEL;
        ST_RECOV: begin
          if (!hiOk)       nextState = ST_DESEL;
          else if (recDone) nextState = ST_NORMAL;
        end
        default:              nextState = ST_DESEL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_DESEL;
    else       curState <= nextState;
  end

  always_comb begin
    strb.allow      = (curState == ST_NORMAL);
    strb.battery    = (curState == ST_BATT);
    strb.recRun     = (curState == ST_RECOV) && hiOk;
    strb.violate    = (curState == ST_NORMAL) && (nextState != ST_NORMAL) && hostWrite;
    strb.graceStart = (curState == ST_NORMAL) && (nextState == ST_DESEL) && hostWrite;
    strb.graceKill  = !loOk || !swOk;
  end
endmodule

// File: rtl/pfail_guard_dp.sv
module pfail_guard_dp
  import pfail_guard_pkg::*;
#(
  parameter int REC_CYC   = 2500000,
  parameter int GRACE_CYC = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  guardStrobeT strb,
  input  logic        hostCe,
  input  logic        hostWe,
  input  logic        hostOe,
  output logic        recDone,
  output logic        memCe,
  output logic        memWe,
  output logic        outEnable,
  output logic        battSel,
  output logic        violation
);
  localparam int RW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
  localparam int GW = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;

  logic [RW-1:0] recCnt;
  logic [GW-1:0] graceCnt;
  logic          graceLive;
  logic          hostWrite;

  assign hostWrite = hostCe && hostWe;
  assign recDone   = strb.recRun && (recCnt == RW'(REC_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            recCnt <= '0;
    else if (!strb.recRun || recDone) recCnt <= '0;
    else                  recCnt <= recCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceLive <= 1'b0;
      graceCnt  <= '0;
    end else if (strb.graceStart) begin
      graceLive <= 1'b1;
      graceCnt  <= '0;
    end else if (graceLive) begin
      if (strb.graceKill || !hostWrite || graceCnt == GW'(GRACE_CYC - 1))
        graceLive <= 1'b0;
      else
        graceCnt <= graceCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) violation <= 1'b0;
    else       violation <= strb.violate;
  end

  always_comb begin
    memCe     = hostCe && (strb.allow || graceLive);
    memWe     = hostWrite && (strb.allow || graceLive);
    outEnable = hostCe && hostOe && !hostWe && strb.allow;
    battSel   = strb.battery;
  end
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfail_guard_pkg::*;
#(
  parameter int CLK_HZ   = 50000000,
  parameter int REC_MS   = 50,
  parameter int GRACE_US = 200,
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyAboveHi,
  input  logic supplyAboveLo,
  input  logic supplyAboveSw,
  input  logic hostCe,
  input  logic hostWe,
  input  logic hostOe,
  output logic memCe,
  output logic memWe,
  output logic outEnable,
  output logic battSel,
  output logic accessOk,
  output logic violation
);
  localparam longint REC_L   = longint'(CLK_HZ) * REC_MS / 1000;
  localparam longint GRACE_L = longint'(CLK_HZ) * GRACE_US / 1000000;
  localparam int REC_CYC   = int'(REC_L);
  localparam int GRACE_CYC = int'(GRACE_L);
  localparam int NFLAG     = 3;

  logic [NFLAG-1:0] rawFlags, cleanFlags;
  guardStrobeT      strb;
  logic             recDone;

  assign rawFlags = {supplyAboveSw, supplyAboveLo, supplyAboveHi};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    pfail_flag_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk(clk), .rstN(rstN), .rawIn(rawFlags[gi]), .cleanOut(cleanFlags[gi])
    );
  end

  pfail_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .hiOk(cleanFlags[0]), .loOk(cleanFlags[1]), .swOk(cleanFlags[2]),
    .hostWrite(hostCe && hostWe), .recDone(recDone), .strb(strb)
  );

  pfail_guard_dp #(.REC_CYC(REC_CYC), .GRACE_CYC(GRACE_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostCe(hostCe), .hostWe(hostWe), .hostOe(hostOe),
    .recDone(recDone), .memCe(memCe), .memWe(memWe),
    .outEnable(outEnable), .battSel(battSel), .violation(violation)
  );

  assign accessOk = strb.allow;
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk (
  input logic clk,
  input logic rstN,
  input logic memCe,
  input logic memWe,
  input logic outEnable,
  input logic battSel,
  input logic accessOk,
  input logic violation
);
  a_r5_no_drive_protected: assert property (@(posedge clk) disable iff (!rstN)
    !accessOk |-> !outEnable);

  a_r6_battery_blocks: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> (!memCe && !memWe && !accessOk));

  a_r6_no_direct_resume: assert property (@(posedge clk) disable iff (!rstN)
    $past(battSel) |-> !accessOk);

  a_r8_no_new_write: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !accessOk) |-> $past(memWe));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> !violation);
endmodule

bind pfail_guard pfail_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .memCe(memCe), .memWe(memWe),
  .outEnable(outEnable), .battSel(battSel), .accessOk(accessOk),
  .violation(violation)
);

// File: tb/pfail_guard_tb_top.sv
module pfail_guard_tb_top;
  localparam int CLK_HZ   = 100000;
  localparam int REC_MS   = 50;
  localparam int GRACE_US = 400;
  localparam int FILT_CYC = 4;
  localparam int REC_CYC  = CLK_HZ / 1000 * REC_MS;   // 5000
  localparam int SLACK    = FILT_CYC + 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic hi = 1'b1, lo = 1'b1, sw = 1'b1;
  logic ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic memCe, memWe, outEnable, battSel, accessOk, violation;
  int total = 0, bad = 0, violCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pfail_guard #(.CLK_HZ(CLK_HZ), .REC_MS(REC_MS), .GRACE_US(GRACE_US),
                .FILT_CYC(FILT_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .supplyAboveHi(hi), .supplyAboveLo(lo),
    .supplyAboveSw(sw), .hostCe(ce), .hostWe(we), .hostOe(oe),
    .memCe(memCe), .memWe(memWe), .outEnable(outEnable), .battSel(battSel),
    .accessOk(accessOk), .violation(violation)
  );

  always @(negedge clk) if (rstN && violation) violCnt++;

  function automatic logic [2:0] expGate(input logic c, w, o, allowed);
    return {c & allowed, c & w & allowed, c & o & ~w & allowed};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measureRecovery(input string req);
    int k = 0;
    while (!accessOk && k < REC_CYC + 100) begin step(1); k++; end
    total++;
    if (k < REC_CYC || k > REC_CYC + SLACK) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, k, REC_CYC, REC_CYC + SLACK);
    end
  endtask

  task automatic randGate(input string req, input int n, input logic allowed);
    for (int i = 0; i < n; i++) begin
      ce = 1'($urandom); we = 1'($urandom); oe = 1'($urandom);
      #1;
      check(req, {memCe, memWe, outEnable}, expGate(ce, we, oe, allowed));
      step(1);
    end
    ce = 0; we = 0; oe = 0;
  endtask

  initial begin
    int v0;
    void'($urandom(32'h5eed1234));
    ce = 1; we = 1; oe = 1;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: protected after reset even with host asserting everything
    check("R1 accessOk", accessOk, 0);
    check("R1 gates", {memCe, memWe, outEnable}, 0);
    ce = 0; we = 0; oe = 0;
    step(2);
    hi = 0; step(12); hi = 1;           // give the filters a clean rise
    measureRecovery("R3 first recovery");
    check("R3 normal", accessOk, 1);

    // R2: pass-through gating in normal state
    randGate("R2 gating", 300, 1'b1);

    // R7: short glitch on upper flag is ignored
    hi = 0; step(FILT_CYC - 1); hi = 1; step(12);
    check("R7 glitch ignored", accessOk, 1);

    // R5 + R9: drop without active write
    v0 = violCnt;
    hi = 0; step(12);
    check("R5 deselected", accessOk, 0);
    check("R9 no violation", violCnt - v0, 0);
    randGate("R5 inputs ignored", 100, 1'b0);

    // R4: dip during recovery restarts the delay
    hi = 1; step(2000);
    check("R4 still protected", accessOk, 0);
    hi = 0; step(12); hi = 1;
    measureRecovery("R4 restarted recovery");

    // R8 + R9: write active at power-down, host releases
    v0 = violCnt;
    ce = 1; we = 1; step(2);
    hi = 0; step(10);
    check("R8 grace keeps write", memWe, 1);
    check("R5 protected during grace", accessOk, 0);
    check("R9 violation pulse", violCnt - v0, 1);
    we = 0; step(2);
    check("R8 release ends write", memWe, 0);
    we = 1; step(2);
    check("R8 no restart", memWe, 0);
    ce = 0; we = 0;
    hi = 1; measureRecovery("R3 recovery after grace");

    // R8: grace timeout
    ce = 1; we = 1; step(2);
    hi = 0; step(30);
    check("R8 within grace", memWe, 1);
    step(30);
    check("R8 grace timeout", memWe, 0);
    ce = 0; we = 0;
    hi = 1; measureRecovery("R3 recovery after timeout");

    // R8: lower threshold ends grace early
    ce = 1; we = 1; step(2);
    hi = 0; step(10);
    lo = 0; step(15);
    check("R8 lower flag kills grace", memWe, 0);
    check("R8 lower flag kills ce", memCe, 0);
    ce = 0; we = 0;

    // R6: battery switchover and return
    sw = 0; step(12);
    check("R6 battery on", battSel, 1);
    ce = 1; we = 1; #1;
    check("R6 no access on battery", {memCe, memWe}, 0);
    ce = 0; we = 0;
    sw = 1; step(12);
    check("R6 battery off", battSel, 0);
    check("R6 still protected", accessOk, 0);
    lo = 1; hi = 1;
    measureRecovery("R6 recovery after battery");
    check("R6 normal again", accessOk, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule